// File: doc/BRIEF.md
# Boundary Deblocking Filter

This block removes the visible seams between 8x8 coded blocks by low-pass filtering the pixels on the edge of each block. It leaves the interior of the block alone. For every pixel the caller supplies a 5x5 neighbourhood centred on that pixel, the pixel's row and column inside its 8x8 block, and a class that says whether the block is smooth ("flat") or has a dominant edge in one of four directions. A flat block gets a small vertical 2D smoothing mask. A block with an edge gets a 5-tap line filter that runs along the edge, so the edge itself is not blurred.

All weights are powers of two on a scale of 1024, so every product is a fixed shift. The shifted terms go through a short adder tree, the sum is divided by 1024 with truncation, and the result is limited to the 8-bit range. The filter is fully pipelined. It accepts one pixel per clock and returns each result exactly two cycles later, with a valid flag that lines up with the data.

Top module: `deblk_boundary_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_pix` are both 0 after that edge.
- R2: A pixel presented with `in_valid` high before clock edge k appears on `out_pix`, with `out_valid` high, after edge k+1 (a latency of two cycles). `out_valid` is low after edge k+1 if `in_valid` was low before edge k. Back-to-back inputs give back-to-back outputs in the same order.
- R3: If both row and column lie in 1..6, the output equals the window centre (row 2, column 2 of the window) unchanged.
- R4: Exactly the 28 positions where row is 0 or 7, or column is 0 or 7, are filtered by the mask that the class selects.
- R5: Class code 0 (flat) gives floor((512*centre + 256*above + 256*below)/1024), where above is window (1,2) and below is window (3,2). Window row 0 is the top row, column 0 is the leftmost column, and pixel (r,c) sits at bits [(r*5+c)*8 +: 8] of `in_win`.
- R6: Class code 1 (horizontal edge direction) uses window row 2, columns 0..4, with weights 32, 256, 256, 256, 32, and the sum is then divided by 1024.
- R7: Class code 3 (vertical edge direction) uses window column 2, rows 0..4, with weights 32, 256, 256, 256, 32.
- R8: Class code 2 (rising diagonal) uses the window cells (4,0), (3,1), (2,2), (1,3) and (0,4), with weights 32, 256, 256, 256, 32.
- R9: Class code 4 (falling diagonal) uses the window cells (0,0), (1,1), (2,2), (3,3) and (4,4), with weights 32, 256, 256, 256, 32.
- R10: Class codes 5, 6 and 7 are treated exactly like class code 0.
- R11: The scaled sum is truncated toward zero, then limited to 0..255. An all-255 flat window gives 255, and an all-255 line window gives 207.
- R12: When no result is due, `out_valid` is low and `out_pix` keeps its last value, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_win | input | 200 | 5x5 neighbourhood, 8 bits per pixel, row-major from the top-left |
| in_class | input | 3 | Edge class of the block the pixel belongs to |
| in_row | input | 3 | Row of the pixel inside its 8x8 block |
| in_col | input | 3 | Column of the pixel inside its 8x8 block |
| out_valid | output | 1 | Result present |
| out_pix | output | 8 | Filtered pixel |

## Verification
The hardest cases to tell apart at the ports are the four line directions. On a window whose values change linearly, every symmetric 5-tap mask returns the same value, so a direction mix-up stays hidden. The bench therefore fills the window with a non-linear pattern in which each cell has a different value, and it applies every class code to that same window. It also sweeps all 64 positions of the block and streams inputs back to back, so that a wrong border decision or a misaligned pipeline stage shows up as a wrong pixel in a known cycle.

// File: rtl/deblk_pkg.sv
package deblk_pkg;

    // Datapath geometry
    localparam int PIX_W  = 8;
    localparam int WIN    = 5;
    localparam int HALF   = WIN / 2;
    localparam int TAPS   = WIN;
    localparam int BLK    = 8;
    localparam int POS_W  = $clog2(BLK);
    localparam int FRAC_W = 10;
    localparam int SH_W   = 4;
    localparam int WIN_W  = WIN * WIN * PIX_W;
    // Room for five terms of up to 2^(FRAC_W-1) times a full-scale pixel
    localparam int SUM_W  = PIX_W + FRAC_W + 3;
    localparam int RES_W  = SUM_W - FRAC_W;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    // Power-of-two weights as shift amounts (weight = 1 << shift, scale 1024)
    localparam int SH_FLAT_C = 9;  // 512
    localparam int SH_FLAT_N = 8;  // 256
    localparam int SH_LINE_I = 8;  // 256
    localparam int SH_LINE_O = 5;  // 32

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [2:0] {
        CLS_FLAT = 3'd0,
        CLS_HOR  = 3'd1,
        CLS_RISE = 3'd2,
        CLS_VER  = 3'd3,
        CLS_FALL = 3'd4
    } edge_cls_e;

    typedef struct packed {
        pix_t            px;
        logic [SH_W-1:0] sh;
        logic            en;
    } tap_t;

    typedef struct packed {
        tap_t [TAPS-1:0] taps;
        pix_t            centre;
        logic            border;
        logic            vld;
    } stage_t;

    function automatic logic on_border(input pos_t r, input pos_t c);
        return (r == '0) || (r == pos_t'(BLK - 1)) ||
               (c == '0) || (c == pos_t'(BLK - 1));
    endfunction

    function automatic pix_t win_px(input logic [WIN_W-1:0] w, input int r, input int c);
        return w[(r * WIN + c) * PIX_W +: PIX_W];
    endfunction

endpackage

// File: rtl/deblk_tap_select.sv
module deblk_tap_select
    import deblk_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    input  edge_cls_e        cls,
    output tap_t [TAPS-1:0]  taps
);

    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            int d;
            int r;
            int c;
            int sh;
            logic en;
            d  = k - HALF;
            r  = HALF;
            c  = HALF;
            en = 1'b1;
            sh = (k == 0 || k == TAPS - 1) ? SH_LINE_O : SH_LINE_I;
            case (cls)
                CLS_HOR:  c = HALF + d;
                CLS_VER:  r = HALF + d;
                CLS_RISE: begin r = HALF - d; c = HALF + d; end
                CLS_FALL: begin r = HALF + d; c = HALF + d; end
                default: begin
                    // flat: centre plus the pixels directly above and below
                    r  = HALF + d;
                    c  = HALF;
                    en = (d >= -1) && (d <= 1);
                    sh = (d == 0) ? SH_FLAT_C : SH_FLAT_N;
                end
            endcase
            taps[k].px = win_px(win, r, c);
            taps[k].sh = SH_W'(sh);
            taps[k].en = en;
        end
    end

endmodule

// File: rtl/deblk_shift_sum.sv
module deblk_shift_sum
    import deblk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t s1,
    output logic   out_valid,
    output pix_t   out_pix
);

    logic [SUM_W-1:0] term [TAPS];
    logic [SUM_W-1:0] pair_a, pair_b, total;
    logic [RES_W-1:0] scaled;
    pix_t             clamped;

    for (genvar k = 0; k < TAPS; k++) begin : g_term
        assign term[k] = s1.taps[k].en ? (SUM_W'(s1.taps[k].px) << s1.taps[k].sh) : '0;
    end

    always_comb begin
        pair_a  = term[0] + term[1];
        pair_b  = term[2] + term[3];
        total   = pair_a + pair_b + term[TAPS-1];
        scaled  = total[SUM_W-1:FRAC_W];
        clamped = (scaled > RES_W'(PIX_MAX)) ? pix_t'(PIX_MAX) : scaled[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1.vld;
            if (s1.vld) begin
                out_pix <= s1.border ? clamped : s1.centre;
            end
        end
    end

    // R3
    interior_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && !s1.border) |=> (out_pix == $past(s1.centre)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !s1.vld |=> ($stable(out_pix) && !out_valid));

endmodule

// File: rtl/deblk_boundary_filter.sv
module deblk_boundary_filter
    import deblk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIN_W-1:0] in_win,
    input  logic [2:0]       in_class,
    input  logic [2:0]       in_row,
    input  logic [2:0]       in_col,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    edge_cls_e       cls;
    tap_t [TAPS-1:0] taps;
    stage_t          s1_d, s1_q;

    assign cls = edge_cls_e'(in_class);

    deblk_tap_select u_sel (
        .win  (in_win),
        .cls  (cls),
        .taps (taps)
    );

    always_comb begin
        s1_d.taps   = taps;
        s1_d.centre = win_px(in_win, HALF, HALF);
        s1_d.border = on_border(pos_t'(in_row), pos_t'(in_col));
        s1_d.vld    = in_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_d;
    end

    deblk_shift_sum u_sum (
        .clk       (clk),
        .rst       (rst),
        .s1        (s1_q),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pix == '0));

    // R2
    latency_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R2
    latency_back_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R5
    flat_unity_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && on_border(pos_t'(in_row), pos_t'(in_col)) && in_class == 3'd0 &&
         win_px(in_win, HALF - 1, HALF) == win_px(in_win, HALF, HALF) &&
         win_px(in_win, HALF + 1, HALF) == win_px(in_win, HALF, HALF))
        |-> ##2 (out_pix == $past(win_px(in_win, HALF, HALF), 2)));

endmodule

// File: tb/deblk_boundary_filter_test.sv
`timescale 1ns/1ps
module deblk_boundary_filter_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [199:0] in_win;
    logic [2:0]   in_class, in_row, in_col;
    logic         out_valid;
    logic [7:0]   out_pix;

    int w [5][5];
    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    deblk_boundary_filter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win),
        .in_class(in_class), .in_row(in_row), .in_col(in_col),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic logic [199:0] pack_win();
        logic [199:0] v;
        v = '0;
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++)
                v[(r*5+c)*8 +: 8] = 8'(w[r][c]);
        return v;
    endfunction

    function automatic int expect_px(int cls, int row, int col);
        int s;
        if (row >= 1 && row <= 6 && col >= 1 && col <= 6) return w[2][2];
        case (cls)
            1: s = 32*w[2][0] + 256*(w[2][1] + w[2][2] + w[2][3]) + 32*w[2][4];
            2: s = 32*w[4][0] + 256*(w[3][1] + w[2][2] + w[1][3]) + 32*w[0][4];
            3: s = 32*w[0][2] + 256*(w[1][2] + w[2][2] + w[3][2]) + 32*w[4][2];
            4: s = 32*w[0][0] + 256*(w[1][1] + w[2][2] + w[3][3]) + 32*w[4][4];
            default: s = 512*w[2][2] + 256*(w[1][2] + w[3][2]);
        endcase
        s = s / 1024;
        return (s > 255) ? 255 : s;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill_pattern(int seed);
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++)
                w[r][c] = (r*r*13 + c*c*c*3 + r*c*5 + seed*29 + 7) % 256;
    endtask

    task automatic fill_const(int v);
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++)
                w[r][c] = v;
    endtask

    // one pixel, full latency check
    task automatic run_one(string req, int cls, int row, int col, int exp);
        @(negedge clk);
        in_win = pack_win(); in_class = 3'(cls); in_row = 3'(row); in_col = 3'(col);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " no early valid (R2)"}, out_valid, 0);
        @(negedge clk);
        chk({req, " valid at 2 (R2)"}, out_valid, 1);
        chk(req, out_pix, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_win = '0; in_class = '0; in_row = '0; in_col = '0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_pix", out_pix, 0);
        rst = 1'b0;
    endtask

    task automatic t_interior();
        fill_pattern(1);
        run_one("R3 (1,1)", 1, 1, 1, w[2][2]);
        run_one("R3 (3,4)", 4, 3, 4, w[2][2]);
        run_one("R3 (6,6)", 0, 6, 6, w[2][2]);
    endtask

    task automatic t_flat();
        fill_pattern(2);
        w[1][2] = 40; w[2][2] = 100; w[3][2] = 200;
        run_one("R5 flat", 0, 0, 3, 110);
        fill_const(90); w[0][0] = 3; w[2][1] = 250;
        run_one("R5 flat uniform column", 0, 7, 7, 90);
    endtask

    task automatic t_directions();
        fill_pattern(3);
        run_one("R6 horizontal", 1, 0, 2, expect_px(1, 0, 2));
        run_one("R7 vertical", 3, 4, 7, expect_px(3, 4, 7));
        run_one("R8 rising", 2, 7, 1, expect_px(2, 7, 1));
        run_one("R9 falling", 4, 5, 0, expect_px(4, 5, 0));
    endtask

    task automatic t_unused_codes();
        fill_pattern(4);
        for (int k = 5; k < 8; k++)
            run_one("R10 unused code", k, 0, 0, expect_px(0, 0, 0));
    endtask

    task automatic t_extremes();
        fill_const(255);
        run_one("R11 flat full scale", 0, 0, 4, 255);
        run_one("R11 line full scale", 3, 7, 3, 207);
        fill_const(0); w[2][2] = 1; w[1][2] = 1;
        run_one("R11 truncation", 0, 2, 0, 0);
    endtask

    // every position, back to back, rotating class
    task automatic t_sweep();
        int exp_q [64];
        fill_pattern(5);
        for (int j = 0; j < 66; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                chk("R2 stream valid", out_valid, 1);
                chk("R4 sweep", out_pix, exp_q[j-2]);
            end
            if (j < 64) begin
                exp_q[j] = expect_px(j % 5, j / 8, j % 8);
                in_win = pack_win(); in_class = 3'(j % 5);
                in_row = 3'(j / 8); in_col = 3'(j % 8);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 stream end", out_valid, 0);
    endtask

    task automatic t_hold();
        int last;
        fill_pattern(6);
        run_one("R12 setup", 1, 0, 5, expect_px(1, 0, 5));
        last = out_pix;
        fill_const(17);
        in_win = pack_win(); in_class = 3'd3; in_row = 3'd0; in_col = 3'd0;
        repeat (4) @(negedge clk);
        chk("R12 valid low", out_valid, 0);
        chk("R12 pixel held", out_pix, last);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_interior();
        t_flat();
        t_directions();
        t_unused_codes();
        t_extremes();
        t_sweep();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule